// File: doc/BRIEF.md
# Ripple-Carry Integer ALU with Signed Set-Less-Than

This block is a purely combinational integer arithmetic and logic unit for a simple processor datapath. Two operands and a 3-bit function code enter, and a result word, a zero flag and a signed-overflow flag leave with no clock or reset involved. The datapath is a column of identical 1-bit slices. Each slice picks among the bitwise AND, the bitwise OR, its adder sum bit and a less-than input. A single ripple carry chain links the adders of the slices.

The top bit of the function code negates the second operand. That one line inverts every bit of `b` and also feeds the carry into the lowest slice, so the same adder performs subtraction in two's complement. For signed set-less-than, the subtraction runs, and a set bit is formed from the sign of the difference corrected by the overflow flag. This set bit goes only to the less-than input of bit 0, so the result is exactly 0 or 1. The zero flag lets equality be tested by subtracting.

Top module: `ripple_slt_alu`

## Requirements
- R1: The function code is `{negate, sel[1:0]}`. Code 3'b000 gives `a & b` and code 3'b001 gives `a | b` on `result`.
- R2: Code 3'b010 gives `result = (a + b) mod 2^32`.
- R3: Code 3'b110 gives `result = (a - b) mod 2^32`. It is formed by inverting `b` and forcing a carry of 1 into bit 0.
- R4: `ovf` equals the carry into the top bit XOR the carry out of the top bit for codes 3'b010, 3'b110 and 3'b111. It is the signed overflow of the addition or subtraction. For every other code `ovf` is 0.
- R5: `zero` is 1 exactly when all 32 bits of `result` are 0.
- R6: Code 3'b111 gives `result = 1` when `a < b` as signed two's complement numbers and `result = 0` otherwise. This holds also when `a - b` overflows. Bits 31..1 of the result are always 0.
- R7: Codes 3'b011, 3'b100 and 3'b101 give `result = 0` and `ovf = 0`, so `zero = 1`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| a | input | 32 | First operand |
| b | input | 32 | Second operand |
| ctrl | input | 3 | Function code {negate, sel[1:0]} |
| result | output | 32 | Selected result word |
| zero | output | 1 | High when result is all zeros |
| ovf | output | 1 | Signed overflow of add, subtract or set-less-than |

## Verification
Uniformly random operand pairs are applied under all eight function codes. These show that each code routes the right slice input and that unlisted codes stay silent. Directed pairs at the signed extremes tell the set bit built from the raw sign apart from the overflow-corrected one. These pairs include most-negative minus one, most-positive plus one, and pairs whose difference wraps. Equal operands under subtraction separate a correct zero flag from one that ignores high bits. Operand pairs with all ones and all zeros expose a wrong carry-in on the negate line.

// File: rtl/rsa_pkg.sv
package rsa_pkg;
  localparam logic [2:0] RSA_AND = 3'b000;
  localparam logic [2:0] RSA_OR  = 3'b001;
  localparam logic [2:0] RSA_ADD = 3'b010;
  localparam logic [2:0] RSA_SUB = 3'b110;
  localparam logic [2:0] RSA_SLT = 3'b111;

  localparam logic [1:0] SEL_AND  = 2'b00;
  localparam logic [1:0] SEL_OR   = 2'b01;
  localparam logic [1:0] SEL_SUM  = 2'b10;
  localparam logic [1:0] SEL_LESS = 2'b11;

  function automatic logic code_is_valid(input logic [2:0] code);
    return (code == RSA_AND) || (code == RSA_OR) || (code == RSA_ADD) ||
           (code == RSA_SUB) || (code == RSA_SLT);
  endfunction

  function automatic logic code_is_arith(input logic [2:0] code);
    return (code == RSA_ADD) || (code == RSA_SUB) || (code == RSA_SLT);
  endfunction
endpackage

// File: rtl/rsa_carry_chain.sv
module rsa_carry_chain #(
  parameter int W = 32
) (
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  input  logic         negate,
  output logic [W-1:0] carry_in_bits,
  output logic         add_ovf,
  output logic         set_bit
);
  logic [W:0]   c;
  logic [W-1:0] bb;

  always_comb begin
    bb   = b ^ {W{negate}};
    c[0] = negate;
    for (int i = 0; i < W; i++) begin
      c[i+1] = (a[i] & bb[i]) | (a[i] & c[i]) | (bb[i] & c[i]);
    end
  end

  assign carry_in_bits = c[W-1:0];
  // overflow: carry into top bit versus carry out of it
  assign add_ovf = c[W] ^ c[W-1];
  // sign of difference, corrected when the subtraction wrapped
  assign set_bit = (a[W-1] ^ bb[W-1] ^ c[W-1]) ^ add_ovf;
endmodule

// File: rtl/rsa_bit_slice.sv
module rsa_bit_slice
  import rsa_pkg::*;
(
  input  logic       a,
  input  logic       b,
  input  logic       negate,
  input  logic       cin,
  input  logic       less,
  input  logic [1:0] sel,
  input  logic       enable,
  output logic       res
);
  logic bb;
  logic picked;

  assign bb = b ^ negate;

  always_comb begin
    unique case (sel)
      SEL_AND:  picked = a & bb;
      SEL_OR:   picked = a | bb;
      SEL_SUM:  picked = a ^ bb ^ cin;
      default:  picked = less;
    endcase
  end

  assign res = enable & picked;
endmodule

// File: rtl/rsa_zero_detect.sv
module rsa_zero_detect #(
  parameter int W = 32
) (
  input  logic [W-1:0] word,
  output logic         is_zero
);
  assign is_zero = ~|word;
endmodule

// File: rtl/ripple_slt_alu.sv
module ripple_slt_alu
  import rsa_pkg::*;
#(
  parameter int W = 32
) (
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  input  logic [2:0]   ctrl,
  output logic [W-1:0] result,
  output logic         zero,
  output logic         ovf
);
  logic         negate;
  logic [1:0]   sel;
  logic         enable;
  logic [W-1:0] cin_bits;
  logic         raw_ovf;
  logic         set_bit;
  logic [W-1:0] res_bits;

  assign negate = ctrl[2];
  assign sel    = ctrl[1:0];
  assign enable = code_is_valid(ctrl);

  rsa_carry_chain #(.W(W)) u_chain (
    .a             (a),
    .b             (b),
    .negate        (negate),
    .carry_in_bits (cin_bits),
    .add_ovf       (raw_ovf),
    .set_bit       (set_bit)
  );

  for (genvar i = 0; i < W; i++) begin : g_slice
    logic less_in;
    if (i == 0) begin : g_lsb
      assign less_in = set_bit;
    end else begin : g_upper
      assign less_in = 1'b0;
    end
    rsa_bit_slice u_slice (
      .a      (a[i]),
      .b      (b[i]),
      .negate (negate),
      .cin    (cin_bits[i]),
      .less   (less_in),
      .sel    (sel),
      .enable (enable),
      .res    (res_bits[i])
    );
  end

  rsa_zero_detect #(.W(W)) u_zero (
    .word    (res_bits),
    .is_zero (zero)
  );

  assign result = res_bits;
  assign ovf    = code_is_arith(ctrl) & raw_ovf;

  always_comb begin
    if (!$isunknown({a, b, ctrl})) begin
      // R1
      a_r1_and: assert (ctrl != RSA_AND || result == (a & b));
      // R2
      a_r2_add: assert (ctrl != RSA_ADD || result == a + b);
      // R3
      a_r3_sub: assert (ctrl != RSA_SUB || result == a - b);
      // R4
      a_r4_no_overflow: assert (code_is_arith(ctrl) || !ovf);
      // R5
      a_r5_zero_flag: assert (zero == (result == '0));
      // R6
      a_r6_slt_value: assert (ctrl != RSA_SLT ||
                              result == {{(W-1){1'b0}}, ($signed(a) < $signed(b))});
      // R7
      a_r7_unlisted_silent: assert (code_is_valid(ctrl) || (result == '0 && zero));
    end
  end
endmodule

// File: tb/ripple_slt_alu_bench.sv
module ripple_slt_alu_bench;
  localparam int CLK_PERIOD = 10;
  localparam int W = 32;

  logic         clk = 1'b0;
  logic [W-1:0] a, b;
  logic [2:0]   ctrl;
  logic [W-1:0] result;
  logic         zero, ovf;
  int n_checks = 0;
  int n_fail = 0;
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  ripple_slt_alu #(.W(W)) u_ripple_slt_alu (
    .a(a), .b(b), .ctrl(ctrl), .result(result), .zero(zero), .ovf(ovf)
  );

  function automatic logic [W-1:0] ref_result(input logic [W-1:0] x, input logic [W-1:0] y,
                                               input logic [2:0] c);
    case (c)
      3'b000: return x & y;
      3'b001: return x | y;
      3'b010: return x + y;
      3'b110: return x - y;
      3'b111: return ($signed(x) < $signed(y)) ? 1 : 0;
      default: return '0;
    endcase
  endfunction

  function automatic logic ref_ovf(input logic [W-1:0] x, input logic [W-1:0] y,
                                   input logic [2:0] c);
    logic [W-1:0] s, d;
    s = x + y;
    d = x - y;
    case (c)
      3'b010: return (x[W-1] == y[W-1]) && (s[W-1] != x[W-1]);
      3'b110, 3'b111: return (x[W-1] != y[W-1]) && (d[W-1] != x[W-1]);
      default: return 1'b0;
    endcase
  endfunction

  function automatic string req_of(input logic [2:0] c);
    case (c)
      3'b000, 3'b001: return "R1";
      3'b010: return "R2";
      3'b110: return "R3";
      3'b111: return "R6";
      default: return "R7";
    endcase
  endfunction

  task automatic apply_check(input logic [W-1:0] x, input logic [W-1:0] y, input logic [2:0] c);
    logic [W-1:0] er;
    logic eo;
    @(negedge clk);
    a = x; b = y; ctrl = c;
    #(CLK_PERIOD/4);
    er = ref_result(x, y, c);
    eo = ref_ovf(x, y, c);
    n_checks++;
    if (result !== er) begin
      n_fail++;
      $display("FAIL %s result ctrl=%b a=%h b=%h actual=%h expected=%h",
               req_of(c), c, x, y, result, er);
    end
    n_checks++;
    if (ovf !== eo) begin
      n_fail++;
      $display("FAIL R4 ovf ctrl=%b a=%h b=%h actual=%b expected=%b", c, x, y, ovf, eo);
    end
    n_checks++;
    if (zero !== (er == '0)) begin
      n_fail++;
      $display("FAIL R5 zero ctrl=%b a=%h b=%h actual=%b expected=%b",
               c, x, y, zero, (er == '0));
    end
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    if (!done) begin
      n_checks++;
      n_fail++;
      $display("FAIL watchdog expired actual=running expected=done");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
      $finish;
    end
  end

  initial begin
    int seed;
    logic [W-1:0] x, y;
    seed = 32'h1234_5678;
    void'($urandom(seed));
    a = '0; b = '0; ctrl = 3'b000;
    // idle state: zero operands, AND (R1, R5)
    apply_check('0, '0, 3'b000);
    // directed corners
    apply_check(32'hFFFF_FFFF, 32'h0000_0001, 3'b010);   // R2 wrap, zero=1
    apply_check(32'h7FFF_FFFF, 32'h0000_0001, 3'b010);   // R4 positive overflow
    apply_check(32'h8000_0000, 32'h8000_0000, 3'b010);   // R4 negative overflow
    apply_check(32'h0000_0000, 32'hFFFF_FFFF, 3'b110);   // R3 carry-in check
    apply_check(32'hDEAD_BEEF, 32'hDEAD_BEEF, 3'b110);   // R3/R5 equality
    apply_check(32'h8000_0000, 32'h0000_0001, 3'b110);   // R4 sub overflow
    apply_check(32'h8000_0000, 32'h0000_0001, 3'b111);   // R6 wrap, still less
    apply_check(32'h7FFF_FFFF, 32'hFFFF_FFFF, 3'b111);   // R6 wrap, not less
    apply_check(32'hFFFF_FFF9, 32'h0000_0006, 3'b111);   // R6 -7 < 6
    apply_check(32'h0000_0005, 32'h0000_0005, 3'b111);   // R6 equal -> 0
    apply_check(32'hFFFF_FFFF, 32'h0000_0000, 3'b111);   // R6 -1 < 0
    apply_check(32'hF0F0_F0F0, 32'h0FF0_0FF0, 3'b000);   // R1
    apply_check(32'hF0F0_F0F0, 32'h0FF0_0FF0, 3'b001);   // R1
    apply_check(32'h7FFF_FFFF, 32'h0000_0001, 3'b011);   // R7
    apply_check(32'hFFFF_FFFF, 32'hFFFF_FFFF, 3'b100);   // R7
    apply_check(32'h8000_0000, 32'h0000_0001, 3'b101);   // R7
    // random sweep over every code
    for (int k = 0; k < 4000; k++) begin
      x = $urandom();
      y = $urandom();
      if (k % 7 == 0) y = x;
      if (k % 11 == 0) x = {x[W-1], {(W-1){~x[W-1]}}};
      apply_check(x, y, 3'(k % 8));
    end
    done = 1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
    $finish;
  end
endmodule